// File: doc/BRIEF.md
# Temperature-Indexed Dual Position Lookup

This block holds a table of two independent 8-bit position codes for each 2 °C band of temperature and presents the pair that belongs to the current temperature. A signed whole-degree reading arrives on a valid/ready stream. The block maps the reading to a band index and reads both channels' entries for that band. It registers the result onto two position outputs.

A plain write port loads table entries one at a time, selecting the channel and band index. The outputs reload only when an accepted reading lands in a band different from the one already active. A write to the entry of the active band reaches the output on the next cycle. Until the first reading is accepted after reset, both outputs stay at zero. The temperature stream never applies back-pressure. Once reset is released, `temp_ready` stays high and every cycle with `temp_valid` high consumes one reading. No reading is ever held or queued.

Top module: `tlu_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, `pos_a` and `pos_b` are 8'h00. `temp_ready` is low while `rst_n` is low.
- R2: An accepted reading T in whole °C (two's complement on `temp_data`) with -40 <= T <= 103 selects band floor((T + 40) / 2). After the accepting clock edge, `pos_a` shows channel A's entry for that band and `pos_b` shows channel B's entry.
- R3: An accepted reading below -40 selects band 0.
- R4: An accepted reading above 103 selects band 71, the last of the 72 bands.
- R5: The outputs change only for two reasons: an accepted reading that selects a band different from the active one, or a write to the active band's entry. A write to any other band leaves them unchanged.
- R6: Channels are independent. `wr_sel` = 0 writes channel A (shown on `pos_a`) and `wr_sel` = 1 writes channel B (shown on `pos_b`). A write to one channel never alters the other channel's entries.
- R7: Once a reading has been accepted, a write to the active band's entry appears on the matching output one clock edge after the write.
- R8: A write with `wr_addr` of 72 or above is discarded. It changes no table entry.
- R9: After reset is released, `temp_ready` is high on every cycle. A reading is consumed on each clock edge at which `temp_valid` is high.
- R10: Before the first reading is accepted after reset, the outputs stay 8'h00 even when band 0 is written.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_valid | input | 1 | Temperature reading present |
| temp_ready | output | 1 | Block accepts a reading (high whenever out of reset) |
| temp_data | input | 8 | Signed temperature in whole °C |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | Channel for the write: 0 = A, 1 = B |
| wr_addr | input | 7 | Band index written (0 to 71 valid) |
| wr_data | input | 8 | Position code written |
| pos_a | output | 8 | Active channel-A position code |
| pos_b | output | 8 | Active channel-B position code |

## Verification
A wrong active band index shows at the ports on the edge after the reading that set it, because both outputs then carry another band's entries. A distinct value is stored in every entry, so any such slip is visible. A corrupted table entry stays hidden until its band becomes active, or until the write-through path is used. For that reason the bench moves through every boundary band and then re-enters a band after writing to it. A lost "first sample seen" flag shows as nonzero outputs right after reset, or as outputs that fail to leave zero on the first reading.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  // number of independent position channels held per band
  localparam int NCH = 2;
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
endpackage

// File: rtl/tlu_index.sv
module tlu_index #(
  parameter int TEMP_W = 8,
  parameter int T_MIN  = -40,
  parameter int STEP   = 2,
  parameter int NBKT   = 72,
  parameter int IDX_W  = 7
) (
  input  logic signed [TEMP_W-1:0] temp,
  output logic        [IDX_W-1:0]  idx
);
  localparam int OFS_W = TEMP_W + 2;

  logic signed [OFS_W-1:0] ofs;
  logic        [OFS_W-1:0] band;

  always_comb begin
    ofs  = OFS_W'(temp) - OFS_W'(T_MIN);
    band = $unsigned(ofs) / OFS_W'(STEP);
    if (ofs < 0)
      idx = '0;
    else if (band >= OFS_W'(NBKT))
      idx = IDX_W'(NBKT - 1);
    else
      idx = band[IDX_W-1:0];
  end
endmodule

// File: rtl/tlu_table.sv
module tlu_table
  import tlu_pkg::*;
#(
  parameter int POS_W = 8,
  parameter int NBKT  = 72,
  parameter int IDX_W = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [CH_W-1:0]                wr_ch,
  input  logic [IDX_W-1:0]               wr_addr,
  input  logic [POS_W-1:0]               wr_data,
  input  logic [IDX_W-1:0]               rd_idx,
  output logic [NCH-1:0][POS_W-1:0]      rd_data
);
  for (genvar c = 0; c < NCH; c++) begin : g_bank
    logic [POS_W-1:0] mem [NBKT];
    logic             hit;

    assign hit = wr_en && (wr_ch == CH_W'(c)) && (wr_addr < IDX_W'(NBKT));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < NBKT; i++) mem[i] <= '0;
      end else if (hit) begin
        mem[wr_addr] <= wr_data;
      end
    end

    assign rd_data[c] = (rd_idx < IDX_W'(NBKT)) ? mem[rd_idx] : '0;
  end
endmodule

// File: rtl/tlu_out.sv
module tlu_out
  import tlu_pkg::*;
#(
  parameter int POS_W = 8,
  parameter int NBKT  = 72,
  parameter int IDX_W = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accept,
  input  logic [IDX_W-1:0]          new_idx,
  input  logic [NCH-1:0][POS_W-1:0] rd_data,
  input  logic                      wr_en,
  input  logic [CH_W-1:0]           wr_ch,
  input  logic [IDX_W-1:0]          wr_addr,
  input  logic [POS_W-1:0]          wr_data,
  output logic [IDX_W-1:0]          cur_idx,
  output logic [NCH-1:0][POS_W-1:0] pos
);
  logic primed;
  logic reload;

  assign reload = accept && (!primed || (new_idx != cur_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      cur_idx <= '0;
    end else if (reload) begin
      primed  <= 1'b1;
      cur_idx <= new_idx;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr_here;
    assign wr_here = wr_en && (wr_ch == CH_W'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pos[c] <= '0;
      end else if (reload) begin
        pos[c] <= (wr_here && (wr_addr == new_idx)) ? wr_data : rd_data[c];
      end else if (primed && wr_here && (wr_addr == cur_idx)) begin
        pos[c] <= wr_data;
      end
    end
  end

  a_r10_zero_until_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> (pos == '0));

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !wr_en) |=> ($stable(pos) && $stable(cur_idx)));

  a_r2_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cur_idx < IDX_W'(NBKT));

  a_r7_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !accept && wr_en && (wr_ch == '0) && (wr_addr == cur_idx))
      |=> (pos[0] == $past(wr_data)));
endmodule

// File: rtl/tlu_ctrl.sv
module tlu_ctrl
  import tlu_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int POS_W  = 8,
  parameter int T_MIN  = -40,
  parameter int T_MAX  = 102,
  parameter int STEP   = 2,
  parameter int NBKT   = (T_MAX - T_MIN) / STEP + 1,
  parameter int IDX_W  = $clog2(NBKT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     temp_valid,
  output logic                     temp_ready,
  input  logic signed [TEMP_W-1:0] temp_data,
  input  logic                     wr_en,
  input  logic                     wr_sel,
  input  logic [IDX_W-1:0]         wr_addr,
  input  logic [POS_W-1:0]         wr_data,
  output logic [POS_W-1:0]         pos_a,
  output logic [POS_W-1:0]         pos_b
);
  logic                      ready_q;
  logic                      accept;
  logic [IDX_W-1:0]          new_idx;
  logic [IDX_W-1:0]          cur_idx;
  logic [NCH-1:0][POS_W-1:0] rd_data;
  logic [NCH-1:0][POS_W-1:0] pos;
  logic [CH_W-1:0]           wr_ch;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign temp_ready = ready_q;
  assign accept     = temp_valid && ready_q;
  assign wr_ch      = CH_W'(wr_sel);

  tlu_index #(
    .TEMP_W(TEMP_W), .T_MIN(T_MIN), .STEP(STEP), .NBKT(NBKT), .IDX_W(IDX_W)
  ) u_index (
    .temp(temp_data),
    .idx (new_idx)
  );

  tlu_table #(
    .POS_W(POS_W), .NBKT(NBKT), .IDX_W(IDX_W)
  ) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_ch  (wr_ch),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_idx (new_idx),
    .rd_data(rd_data)
  );

  tlu_out #(
    .POS_W(POS_W), .NBKT(NBKT), .IDX_W(IDX_W)
  ) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .new_idx(new_idx),
    .rd_data(rd_data),
    .wr_en  (wr_en),
    .wr_ch  (wr_ch),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .cur_idx(cur_idx),
    .pos    (pos)
  );

  assign pos_a = pos[0];
  assign pos_b = pos[1];

  a_r9_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> temp_ready);

  a_r3_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (temp_data < T_MIN)) |=> (cur_idx == '0));

  a_r4_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (temp_data > T_MAX + STEP - 1)) |=> (cur_idx == IDX_W'(NBKT - 1)));

  a_r1_outputs_zero_in_reset: assert property (@(posedge clk)
    $past(!rst_n) |-> ((pos_a == '0) && (pos_b == '0)));
endmodule

// File: tb/test_tlu_ctrl.sv
`timescale 1ns/1ps
module test_tlu_ctrl;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              temp_valid = 1'b0;
  logic              temp_ready;
  logic signed [7:0] temp_data = '0;
  logic              wr_en = 1'b0;
  logic              wr_sel = 1'b0;
  logic [6:0]        wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [7:0]        pos_a, pos_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tlu_ctrl i_tlu_ctrl (
    .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_ready(temp_ready),
    .temp_data(temp_data), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .pos_a(pos_a), .pos_b(pos_b)
  );

  localparam int NV = 14;
  localparam int VT [NV] = '{-128, -41, -40, -39, -38, 0, 1, 25, 101, 102, 103, 104, 127, -1};
  localparam int VI [NV] = '{   0,   0,   0,   0,   1, 20, 20, 32, 70, 71, 71, 71, 71, 19};

  function automatic logic [7:0] ent_a(int i); return 8'(i * 3 + 1); endfunction
  function automatic logic [7:0] ent_b(int i); return 8'(255 - 2 * i); endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sample(int t);
    @(negedge clk);
    temp_valid = 1'b1;
    temp_data  = 8'(t);
    @(negedge clk);
    temp_valid = 1'b0;
  endtask

  task automatic wr(logic ch, int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = ch; wr_addr = 7'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pos_a in reset", pos_a, 8'h00);
    chk("R1 pos_b in reset", pos_b, 8'h00);
    chk("R1 ready low in reset", {7'd0, temp_ready}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pos_a after reset", pos_a, 8'h00);
    chk("R9 ready high", {7'd0, temp_ready}, 8'h01);
    // R10: write band 0 before any sample
    wr(1'b0, 0, 8'h5A);
    chk("R10 pos_a before first sample", pos_a, 8'h00);
    // load full table
    for (int i = 0; i < 72; i++) begin
      wr(1'b0, i, ent_a(i));
      wr(1'b1, i, ent_b(i));
    end
    chk("R10 pos_b before first sample", pos_b, 8'h00);
    // vector walk: R2, R3, R4, R9
    for (int v = 0; v < NV; v++) begin
      sample(VT[v]);
      chk("R2/R3/R4 pos_a band", pos_a, ent_a(VI[v]));
      chk("R2/R3/R4 pos_b band", pos_b, ent_b(VI[v]));
    end
    // now at band 19
    // R5: write to other band leaves outputs unchanged
    wr(1'b0, 30, 8'hC3);
    chk("R5 pos_a unchanged by other-band write", pos_a, ent_a(19));
    sample(-1);
    chk("R5 same band resample pos_a", pos_a, ent_a(19));
    // R7: write to active band visible next cycle
    wr(1'b0, 19, 8'hE7);
    chk("R7 write-through pos_a", pos_a, 8'hE7);
    // R6: channel B untouched by channel A write
    chk("R6 pos_b unaffected", pos_b, ent_b(19));
    wr(1'b1, 19, 8'h11);
    chk("R6 pos_b write-through", pos_b, 8'h11);
    chk("R6 pos_a unaffected by B write", pos_a, 8'hE7);
    // R5: band 30 write shows when band entered
    sample(20);
    chk("R5 written band 30 pos_a", pos_a, 8'hC3);
    chk("R6 band 30 pos_b", pos_b, ent_b(30));
    // R8: out-of-range writes discarded
    wr(1'b0, 72, 8'h99);
    wr(1'b0, 100, 8'h98);
    wr(1'b1, 127, 8'h97);
    sample(127);
    chk("R8 band 71 pos_a intact", pos_a, ent_a(71));
    chk("R8 band 71 pos_b intact", pos_b, ent_b(71));
    sample(-40);
    chk("R8 band 0 pos_a intact", pos_a, ent_a(0));
    chk("R8 band 0 pos_b intact", pos_b, ent_b(0));
    // R9: back-to-back readings each consumed
    @(negedge clk);
    temp_valid = 1'b1; temp_data = 8'sd60;
    @(negedge clk);
    chk("R9 first of burst", pos_a, ent_a(50));
    temp_data = 8'sd62;
    @(negedge clk);
    temp_valid = 1'b0;
    chk("R9 second of burst", pos_a, ent_a(51));
    chk("R9 ready still high", {7'd0, temp_ready}, 8'h01);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule